// File: doc/BRIEF.md
# Two-Layer Locked Majority Cone

This block computes a majority vote over a small input bus and protects it with two key layers that depend on each other. The first layer is a row of XOR/XNOR key gates on the leaf wires of the majority cone, driven by the cone key. The second layer is a point-function flip unit on the same output. Its key is first mixed with the cone key, and the mixed value is compared against the low input bits. On a match the cone result is inverted, unless the mixed value equals the mix of the two correct keys. That mask stops the correct key from ever flipping the output.

Because the cone key also drives the mixing, the flip unit's trigger point is unknown while the cone key is unknown. The flip logic therefore cannot be stripped out or solved apart from the cone. The mixing rule is a parameter: bitwise XOR, modular addition, or a rotation whose amount comes from the cone key. The block is purely combinational. The correct keys are parameters, so the mask reference is a constant fixed at elaboration.

Top module: `lockedConeTwoLayer`

## Requirements
- R1: With keyCone equal to CORRECT_K1 and keyFlip equal to CORRECT_K2, lockedOut equals 1 exactly when more than IN_W/2 bits of inPattern are 1, for every input pattern.
- R2: Bit i of keyCone (i < KEY_W) meets input bit i through an XNOR gate where CORRECT_K1[i] is 1 and through an XOR gate where it is 0. The cone therefore computes the majority of inPattern XOR keyCone XOR CORRECT_K1, with bits at KEY_W and above passed straight through.
- R3: With the correct cone key and a wrong flip key, lockedOut differs from the true majority for exactly one input pattern. That pattern is the one whose low KEY_W bits equal the mixed key.
- R4: When the mixed key equals the mix of CORRECT_K2 with CORRECT_K1, the flip unit never inverts the output, whatever the input.
- R5: With SCR_MODE 0, the mixed key is keyFlip XOR keyCone.
- R6: With SCR_MODE 1, the mixed key is (keyFlip + keyCone) mod 2^KEY_W.
- R7: With SCR_MODE 2, the mixed key is keyFlip rotated left, with bit i moving to position (i + a) mod KEY_W, where a = keyCone mod KEY_W.
- R8: Every key pair other than the correct one gives a wrong output for at least one input pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inPattern | input | IN_W | Primary input bus of the majority cone |
| keyCone | input | KEY_W | Key for the in-cone gates, also the mixing key |
| keyFlip | input | KEY_W | Key for the point-function flip unit |
| lockedOut | output | 1 | Locked majority result |

## Verification
The assertions assume that IN_W is odd and that KEY_W is no larger than IN_W. Under those conditions the majority is well defined and every key gate sits on a real input wire. They also assume that all inputs carry known values whenever they are evaluated. The bench uses a 5-bit bus with 5-bit keys and drives only defined values. It sweeps every pattern under every key pair for all three mixing modes, so each corner is reached, including wrong key pairs whose mixed value lands on the masked point.

// File: rtl/lockPkg.sv
`timescale 1ns/1ps
package lockPkg;
  // mixing rules for the flip key
  localparam int SCR_XOR = 0;
  localparam int SCR_ADD = 1;
  localparam int SCR_ROT = 2;

  // strobes from flip control to the cone datapath
  typedef struct packed {
    logic match;   // low input bits equal mixed key
    logic masked;  // mixed key sits on the correct point
    logic flip;    // invert the cone result
  } flipStrobes_t;
endpackage

// File: rtl/keyScrambler.sv
`timescale 1ns/1ps
module keyScrambler #(
  parameter int KEY_W = 5,
  parameter int MODE  = 0
) (
  input  logic [KEY_W-1:0] flipKey,
  input  logic [KEY_W-1:0] mixKey,
  output logic [KEY_W-1:0] scrambled
);
  import lockPkg::*;

  generate
    if (MODE == SCR_XOR) begin : g_xor
      assign scrambled = flipKey ^ mixKey;
      always_comb begin
        // R5
        xor_inverse_chk: assert ((scrambled ^ mixKey) == flipKey);
      end
    end else if (MODE == SCR_ADD) begin : g_add
      logic [KEY_W-1:0] backDiff;
      assign scrambled = flipKey + mixKey;
      assign backDiff  = scrambled - mixKey;
      always_comb begin
        // R6
        add_inverse_chk: assert (backDiff == flipKey);
      end
    end else begin : g_rot
      int rotAmt;
      always_comb begin
        rotAmt = int'(mixKey) % KEY_W;
        scrambled = '0;
        for (int i = 0; i < KEY_W; i++) begin
          scrambled[(i + rotAmt) % KEY_W] = flipKey[i];
        end
      end
      always_comb begin
        // R7
        rot_weight_chk: assert ($countones(scrambled) == $countones(flipKey));
        // R7
        rot_zero_chk: assert ((rotAmt != 0) || (scrambled == flipKey));
      end
    end
  endgenerate
endmodule

// File: rtl/flipCtrl.sv
`timescale 1ns/1ps
module flipCtrl #(
  parameter int KEY_W = 5
) (
  input  logic [KEY_W-1:0]     cmpBits,
  input  logic [KEY_W-1:0]     scrambled,
  input  logic [KEY_W-1:0]     scrambledRef,
  output lockPkg::flipStrobes_t strb
);
  always_comb begin
    strb.match  = (cmpBits == scrambled);
    strb.masked = (scrambled == scrambledRef);
    strb.flip   = strb.match & ~strb.masked;
  end
endmodule

// File: rtl/coneDatapath.sv
`timescale 1ns/1ps
module coneDatapath #(
  parameter int              IN_W       = 5,
  parameter int              KEY_W      = 5,
  parameter logic [KEY_W-1:0] CORRECT_K1 = '0
) (
  input  logic [IN_W-1:0]      inPattern,
  input  logic [KEY_W-1:0]     keyCone,
  input  lockPkg::flipStrobes_t strb,
  output logic                 coneRaw,
  output logic                 lockedOut
);
  localparam int CNT_W  = $clog2(IN_W + 1);
  localparam int HALF_W = IN_W / 2;

  logic [IN_W-1:0]  leafWire;
  logic [CNT_W-1:0] onesCnt;

  // key gates: XNOR where the correct bit is 1 (absorbed inverter)
  generate
    for (genvar i = 0; i < IN_W; i++) begin : g_leaf
      if (i < KEY_W) begin : g_keyed
        if (CORRECT_K1[i]) begin : g_xnor
          assign leafWire[i] = ~(inPattern[i] ^ keyCone[i]);
        end else begin : g_xor
          assign leafWire[i] = inPattern[i] ^ keyCone[i];
        end
      end else begin : g_plain
        assign leafWire[i] = inPattern[i];
      end
    end
  endgenerate

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < IN_W; i++) begin
      onesCnt = onesCnt + CNT_W'(leafWire[i]);
    end
  end

  assign coneRaw   = (onesCnt > CNT_W'(HALF_W));
  assign lockedOut = coneRaw ^ strb.flip;

  always_comb begin
    // R2
    key_gate_polarity_chk: assert ($countones(leafWire ^ inPattern) ==
                                   $countones(keyCone ^ CORRECT_K1));
    // R4
    masked_no_flip_chk: assert (!strb.masked || (lockedOut == coneRaw));
  end
endmodule

// File: rtl/lockedConeTwoLayer.sv
`timescale 1ns/1ps
module lockedConeTwoLayer #(
  parameter int               IN_W       = 5,
  parameter int               KEY_W      = 5,
  parameter int               SCR_MODE   = 0,
  parameter logic [KEY_W-1:0] CORRECT_K1 = 5'b10110,
  parameter logic [KEY_W-1:0] CORRECT_K2 = 5'b01011
) (
  input  logic [IN_W-1:0]  inPattern,
  input  logic [KEY_W-1:0] keyCone,
  input  logic [KEY_W-1:0] keyFlip,
  output logic             lockedOut
);
  localparam logic [KEY_W-1:0] REF_CONE = CORRECT_K1;
  localparam logic [KEY_W-1:0] REF_FLIP = CORRECT_K2;

  logic [KEY_W-1:0]      scrambled;
  logic [KEY_W-1:0]      scrambledRef;
  lockPkg::flipStrobes_t strb;
  logic                  coneRaw;

  keyScrambler #(.KEY_W(KEY_W), .MODE(SCR_MODE)) u_scr (
    .flipKey(keyFlip), .mixKey(keyCone), .scrambled(scrambled)
  );

  // constant mask point, folded at elaboration
  keyScrambler #(.KEY_W(KEY_W), .MODE(SCR_MODE)) u_scrRef (
    .flipKey(REF_FLIP), .mixKey(REF_CONE), .scrambled(scrambledRef)
  );

  flipCtrl #(.KEY_W(KEY_W)) u_ctrl (
    .cmpBits(inPattern[KEY_W-1:0]), .scrambled(scrambled),
    .scrambledRef(scrambledRef), .strb(strb)
  );

  coneDatapath #(.IN_W(IN_W), .KEY_W(KEY_W), .CORRECT_K1(CORRECT_K1)) u_dp (
    .inPattern(inPattern), .keyCone(keyCone), .strb(strb),
    .coneRaw(coneRaw), .lockedOut(lockedOut)
  );

  always_comb begin
    // R1
    correct_pair_majority_chk: assert (!((keyCone == CORRECT_K1) && (keyFlip == CORRECT_K2)) ||
                                       (lockedOut == ($countones(inPattern) > (IN_W / 2))));
    // R3
    single_corrupt_point_chk: assert (!((keyCone == CORRECT_K1) &&
                                        (lockedOut != ($countones(inPattern) > (IN_W / 2)))) ||
                                      (inPattern[KEY_W-1:0] == scrambled));
  end
endmodule

// File: tb/lockedConeTwoLayer_tb.sv
`timescale 1ns/1ps
module lockedConeTwoLayer_tb;
  localparam int W = 5;
  localparam logic [W-1:0] C1 = 5'b10110;
  localparam logic [W-1:0] C2 = 5'b01011;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic         rstN;
  logic [W-1:0] inPattern, keyCone, keyFlip;
  logic         outX, outA, outR;
  int           checks = 0;
  int           fails  = 0;
  bit           done   = 1'b0;

  lockedConeTwoLayer #(.IN_W(W), .KEY_W(W), .SCR_MODE(0), .CORRECT_K1(C1), .CORRECT_K2(C2)) u_dut (
    .inPattern(inPattern), .keyCone(keyCone), .keyFlip(keyFlip), .lockedOut(outX));
  lockedConeTwoLayer #(.IN_W(W), .KEY_W(W), .SCR_MODE(1), .CORRECT_K1(C1), .CORRECT_K2(C2)) u_dutAdd (
    .inPattern(inPattern), .keyCone(keyCone), .keyFlip(keyFlip), .lockedOut(outA));
  lockedConeTwoLayer #(.IN_W(W), .KEY_W(W), .SCR_MODE(2), .CORRECT_K1(C1), .CORRECT_K2(C2)) u_dutRot (
    .inPattern(inPattern), .keyCone(keyCone), .keyFlip(keyFlip), .lockedOut(outR));

  function automatic bit majRef(input int x);
    logic [W-1:0] v;
    v = W'(x);
    return ($countones(v) > W / 2);
  endfunction

  function automatic int scrRef(input int mode, input int k2, input int k1);
    int r;
    int a;
    if (mode == 0) return (k2 ^ k1) & 31;
    if (mode == 1) return (k2 + k1) % 32;
    a = k1 % W;
    r = 0;
    for (int i = 0; i < W; i++) if ((k2 >> i) & 1) r = r | (1 << ((i + a) % W));
    return r;
  endfunction

  function automatic bit pickOut(input int mode);
    if (mode == 0) return outX;
    if (mode == 1) return outA;
    return outR;
  endfunction

  task automatic checkBit(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (k1=%0d k2=%0d in=%0d)",
               tag, got, exp, keyCone, keyFlip, inPattern);
    end
  endtask

  task automatic checkCount(input int got, input int lo, input int hi, input string tag);
    checks++;
    if (got < lo || got > hi) begin
      fails++;
      $display("FAIL %s: got %0d corrupt patterns expected %0d..%0d (k1=%0d k2=%0d)",
               tag, got, lo, hi, keyCone, keyFlip);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    inPattern = '0; keyCone = C1; keyFlip = C2;
    repeat (4) @(posedge clk);
    rstN = 1'b1;

    // initial state: correct keys, all-zero input gives 0 (R1)
    @(negedge clk); #1;
    checkBit(outX, 1'b0, "R1 start xor");
    checkBit(outA, 1'b0, "R1 start add");
    checkBit(outR, 1'b0, "R1 start rot");

    for (int k1 = 0; k1 < 32; k1++) begin
      for (int k2 = 0; k2 < 32; k2++) begin
        int errs[3];
        for (int m = 0; m < 3; m++) errs[m] = 0;
        for (int p = 0; p < 32; p++) begin
          @(negedge clk);
          inPattern = W'(p); keyCone = W'(k1); keyFlip = W'(k2);
          #1;
          for (int m = 0; m < 3; m++) begin
            int  s;
            int  sc;
            bit  cone;
            bit  flip;
            bit  got;
            s    = scrRef(m, k2, k1);
            sc   = scrRef(m, int'(C2), int'(C1));
            cone = majRef(p ^ k1 ^ int'(C1));
            flip = (p == s) && (s != sc);
            got  = pickOut(m);
            if (m == 0) checkBit(got, cone ^ flip, "R2 R5 model");
            else if (m == 1) checkBit(got, cone ^ flip, "R2 R6 model");
            else checkBit(got, cone ^ flip, "R2 R7 model");
            if (s == sc && p == s) checkBit(got, cone, "R4 masked point");
            if (got != majRef(p)) errs[m]++;
          end
        end
        for (int m = 0; m < 3; m++) begin
          if (k1 == int'(C1) && k2 == int'(C2)) checkCount(errs[m], 0, 0, "R1 correct pair");
          else if (k1 == int'(C1)) checkCount(errs[m], 1, 1, "R3 wrong flip key");
          else checkCount(errs[m], 1, 32, "R8 wrong cone key");
        end
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule